// File: doc/BRIEF.md
# PCI Express Capability Register Block

This block holds the PCI Express capability structure of a single endpoint function. Configuration software reaches it through dword-indexed read and write strobes with per-byte enables. Each field behaves according to its own access class. Capability words are constants taken from elaboration parameters. Control fields can be read and written. Status flags are set by event inputs and cleared by writing 1. A group of link-control-2 fields is sticky: those fields are cleared only by power-on reset.

The block has two reset inputs. A power-on reset returns every field to its default, the sticky group included. A hot reset returns only the non-sticky fields. Writing 1 to the function-reset trigger in device control produces a one-cycle `flr_pulse` for the rest of the function. That pulse also acts on the register block: on the following clock edge it restores every non-sticky field, in the same way a hot reset does. The trigger works only when the function-reset capability parameter is set.

Read data appears one clock after the read strobe. Dword indices that hold no register read as zero.

Top module: `pcie_cap_regs`

## Requirements
- R1: Dword indices 0 (header), 1 (device capabilities), 3 (link capabilities), 9 (device capabilities 2) and 11 (link capabilities 2) read constant words built from the parameters. Header: ID in [7:0], next pointer in [15:8], version in [19:16]. Device capabilities: [15] reads 1 and [28] is the function-reset capability. Link capabilities: [22] reads 1. All reserved bits read 0 and ignore writes.
- R2: `cfg_rdata` carries the addressed word in the cycle after `cfg_rd`. It reads 0 for indices 5-8 and 13 and above, and it reads 0 in any cycle that does not follow a read.
- R3: Device control (index 2, bits [15:0]) resets to 0x2800 with the relaxed-ordering bit [4] taken from a parameter. Bits [8:0] and [14:11] are writable. Bits [10:9] are not writable. Each byte is written only when its enable is high.
- R4: A write to index 2 with byte enable 1 high and data bit 15 at 1 drives `flr_pulse` high for exactly one cycle, but only when the function-reset capability parameter is 1. Bit 15 always reads 0.
- R5: The clock edge that follows `flr_pulse` restores device control, device status, device control 2, link control, link control 2 bit 5 and link status 2 bit 21 to their defaults.
- R6: Device status bits [19:16] (correctable, non-fatal, fatal, unsupported request) are set from `err_event[3:0]` and cleared by writing 1 through byte enable 2. When a set and a clear land on the same bit in the same cycle, the set wins.
- R7: Device status bit 21 reads the `txn_pending` input. Writes do not change it.
- R8: Link control (index 4) has writable bits 0, 1, 3, 6 and 7 and resets to 0. Its status half reads `link_speed` in [19:16], `link_width` in [25:20] and the slot-clock parameter in [28].
- R9: Device control 2 (index 10) resets to 0x1F. Bits [4:0] and [6] are writable.
- R10: Link control 2 (index 12) bits [4:0] and [15:7] are sticky. They hold their values through a hot reset and a function reset, and power-on reset sets them to the maximum link speed in [3:0] with 0 elsewhere. Bit 5 is writable, is not sticky, and resets to 0.
- R11: Link status 2 bits [20:17] read `eq_status[3:0]`. Bit 21 is set by `eq_req` and cleared by writing 1 through byte enable 2. When both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all fields including sticky ones |
| hot_rst_n | input | 1 | Hot reset, active low, clears non-sticky fields |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | ADDR_W | Dword index within the structure |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| err_event | input | 4 | Error events: [0] correctable, [1] non-fatal, [2] fatal, [3] unsupported request |
| txn_pending | input | 1 | A non-posted request of the function is outstanding |
| link_speed | input | 4 | Negotiated link speed |
| link_width | input | 6 | Negotiated link width |
| eq_status | input | 4 | Equalization complete and phase 1-3 success flags |
| eq_req | input | 1 | Link equalization request event |
| flr_pulse | output | 1 | One-cycle function reset pulse |

## Verification
The bench aims at the following corner cases:

- **Same-cycle set and clear.** Error flags and the equalization-request flag receive a write-1-to-clear in the same cycle as their set event. A design that gave the clear priority would lose the event.
- **Sticky fields under the two resets.** The sticky link-control-2 fields are taken through a hot reset and a function reset, and then through a power-on reset. A design with the reset classes swapped would either wipe the speed target or keep a stale margin setting.
- **Function-reset trigger.** The trigger is written with its byte enable off, with it on, and on a second instance built without the capability. A wrong gate or a stretched pulse appears on `flr_pulse`.
- **Address sweep and byte-enable sweep.** Every address is read, and every byte-enable pattern is written to device control. This exposes reserved bits that leak, holes that do not read zero, and byte lanes that are wired to the wrong enable.

// File: rtl/pcie_cap_pkg.sv
package pcie_cap_pkg;

  localparam int WORD_W = 32;

  // dword indices inside the structure; software decodes these positions
  localparam int IDX_HDR     = 0;
  localparam int IDX_DEVCAP  = 1;
  localparam int IDX_DEVCTL  = 2;
  localparam int IDX_LNKCAP  = 3;
  localparam int IDX_LNKCTL  = 4;
  localparam int IDX_DEVCAP2 = 9;
  localparam int IDX_DEVCTL2 = 10;
  localparam int IDX_LNKCAP2 = 11;
  localparam int IDX_LNKCTL2 = 12;

  localparam logic [WORD_W-1:0] DEVCTL_WMASK   = 32'h0000_79FF;
  localparam logic [WORD_W-1:0] DEVCTL_BASE    = 32'h0000_2800;
  localparam logic [WORD_W-1:0] LNKCTL_WMASK   = 32'h0000_00CB;
  localparam logic [WORD_W-1:0] DEVCTL2_WMASK  = 32'h0000_005F;
  localparam logic [WORD_W-1:0] DEVCTL2_DEF    = 32'h0000_001F;
  localparam logic [WORD_W-1:0] LC2_STICKY_MSK = 32'h0000_FF9F;

  // expand byte enables into a per-bit lane mask
  function automatic logic [WORD_W-1:0] lane_mask(input logic [3:0] be);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // read-write merge restricted to writable bits and enabled bytes
  function automatic logic [WORD_W-1:0] rw_merge(input logic [WORD_W-1:0] cur,
                                                 input logic [WORD_W-1:0] wd,
                                                 input logic [3:0] be,
                                                 input logic [WORD_W-1:0] wmask);
    logic [WORD_W-1:0] sel;
    sel = lane_mask(be) & wmask;
    return (cur & ~sel) | (wd & sel);
  endfunction

endpackage

// File: rtl/pcie_cap_dev.sv
module pcie_cap_dev import pcie_cap_pkg::*; #(
  parameter bit FLR_CAP = 1'b1,
  parameter bit RO_DEF  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_devctl,
  input  logic              wr_devctl2,
  input  logic [WORD_W-1:0] wdata,
  input  logic [3:0]        be,
  input  logic [3:0]        err_in,
  input  logic              txn_pending,
  output logic [WORD_W-1:0] devctl_word,
  output logic [WORD_W-1:0] devctl2_word,
  output logic              flr_pulse
);

  localparam logic [WORD_W-1:0] CTL_DEF = DEVCTL_BASE | (WORD_W'(RO_DEF) << 4);

  logic [WORD_W-1:0] ctl_q, ctl2_q;
  logic [3:0]        sts_q, sts_clr;
  logic              flr_q, flr_req;

  assign flr_req = wr_devctl & be[1] & wdata[15] & FLR_CAP & ~flr_q;
  assign sts_clr = (wr_devctl & be[2]) ? wdata[19:16] : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_DEF;
      ctl2_q <= DEVCTL2_DEF;
      sts_q  <= '0;
      flr_q  <= 1'b0;
    end else if (flr_q) begin
      ctl_q  <= CTL_DEF;
      ctl2_q <= DEVCTL2_DEF;
      sts_q  <= '0;
      flr_q  <= 1'b0;
    end else begin
      flr_q <= flr_req;
      if (wr_devctl)  ctl_q  <= rw_merge(ctl_q, wdata, be, DEVCTL_WMASK);
      if (wr_devctl2) ctl2_q <= rw_merge(ctl2_q, wdata, be, DEVCTL2_WMASK);
      sts_q <= (sts_q & ~sts_clr) | err_in;
    end
  end

  assign devctl_word  = {10'b0, txn_pending, 1'b0, sts_q, ctl_q[15:0]};
  assign devctl2_word = ctl2_q;
  assign flr_pulse    = flr_q;

  assert_flr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flr_q |=> !flr_q);
  assert_flr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flr_q |-> $past(wr_devctl && be[1] && wdata[15]));
  assert_flr_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flr_q |=> (ctl_q == CTL_DEF && sts_q == 4'b0 && ctl2_q == DEVCTL2_DEF));
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in != 4'b0 && !flr_q) |=> ((sts_q & $past(err_in)) == $past(err_in)));

endmodule

// File: rtl/pcie_cap_link.sv
module pcie_cap_link import pcie_cap_pkg::*; #(
  parameter logic [3:0] TGT_DEF = 4'd3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              flr_clear,
  input  logic              wr_lnkctl,
  input  logic              wr_lnkctl2,
  input  logic [WORD_W-1:0] wdata,
  input  logic [3:0]        be,
  input  logic [3:0]        eq_status,
  input  logic              eq_req,
  output logic [WORD_W-1:0] lnkctl_word,
  output logic [WORD_W-1:0] lnkctl2_word
);

  logic [WORD_W-1:0] lc_q, lc2_st;
  logic              hasd_q, eqreq_q, eq_clr;

  assign eq_clr = wr_lnkctl2 & be[2] & wdata[21];

  // sticky group: only power-on reset reaches it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          lc2_st <= WORD_W'(TGT_DEF);
    else if (wr_lnkctl2) lc2_st <= rw_merge(lc2_st, wdata, be, LC2_STICKY_MSK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q    <= '0;
      hasd_q  <= 1'b0;
      eqreq_q <= 1'b0;
    end else if (flr_clear) begin
      lc_q    <= '0;
      hasd_q  <= 1'b0;
      eqreq_q <= 1'b0;
    end else begin
      if (wr_lnkctl) lc_q <= rw_merge(lc_q, wdata, be, LNKCTL_WMASK);
      if (wr_lnkctl2 && be[0]) hasd_q <= wdata[5];
      eqreq_q <= (eqreq_q & ~eq_clr) | eq_req;
    end
  end

  assign lnkctl_word  = lc_q;
  assign lnkctl2_word = lc2_st | {26'b0, hasd_q, 5'b0} | {10'b0, eqreq_q, eq_status, 17'b0};

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
    (flr_clear && !wr_lnkctl2) |=> $stable(lc2_st));
  assert_flr_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flr_clear |=> (lc_q == '0 && !hasd_q && !eqreq_q));
  assert_eq_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_req && !flr_clear) |=> eqreq_q);

endmodule

// File: rtl/pcie_cap_regs.sv
module pcie_cap_regs import pcie_cap_pkg::*; #(
  parameter int         ADDR_W      = 6,
  parameter logic [7:0] CAP_ID      = 8'h10,
  parameter logic [7:0] NEXT_PTR    = 8'h00,
  parameter logic [3:0] CAP_VER     = 4'h2,
  parameter logic [2:0] MPS_SUP     = 3'd1,
  parameter bit         EXT_TAG     = 1'b1,
  parameter logic [2:0] L0S_ACC     = 3'd7,
  parameter logic [2:0] L1_ACC      = 3'd7,
  parameter bit         FLR_CAP     = 1'b1,
  parameter bit         RO_DEF      = 1'b1,
  parameter logic [3:0] MAX_SPEED   = 4'd3,
  parameter logic [5:0] MAX_WIDTH   = 6'd8,
  parameter bit         ASPM_L0S    = 1'b1,
  parameter bit         ASPM_L1     = 1'b1,
  parameter logic [2:0] L0S_EXIT    = 3'd6,
  parameter logic [2:0] L1_EXIT     = 3'd0,
  parameter bit         SLOT_CLK    = 1'b1,
  parameter logic [3:0] CTO_RANGES  = 4'hF,
  parameter bit         CTO_DIS_SUP = 1'b1,
  parameter logic [2:0] SPEED_VEC   = 3'b111
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hot_rst_n,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  output logic [31:0]       cfg_rdata,
  input  logic [3:0]        err_event,
  input  logic              txn_pending,
  input  logic [3:0]        link_speed,
  input  logic [5:0]        link_width,
  input  logic [3:0]        eq_status,
  input  logic              eq_req,
  output logic              flr_pulse
);

  localparam logic [WORD_W-1:0] HDR_WORD = {12'h0, CAP_VER, NEXT_PTR, CAP_ID};
  localparam logic [WORD_W-1:0] DEVCAP_WORD =
    {3'b0, FLR_CAP, 12'b0, 1'b1, 3'b0, L1_ACC, L0S_ACC, EXT_TAG, 2'b0, MPS_SUP};
  localparam logic [WORD_W-1:0] LNKCAP_WORD =
    {9'b0, 1'b1, 4'b0, L1_EXIT, L0S_EXIT, ASPM_L1, ASPM_L0S, MAX_WIDTH, MAX_SPEED};
  localparam logic [WORD_W-1:0] DEVCAP2_WORD = {27'b0, CTO_DIS_SUP, CTO_RANGES};
  localparam logic [WORD_W-1:0] LNKCAP2_WORD = {28'b0, SPEED_VEC, 1'b0};

  logic              nonsticky_rst_n;
  logic              wr_devctl, wr_devctl2, wr_lnkctl, wr_lnkctl2, addr_hole;
  logic [WORD_W-1:0] devctl_word, devctl2_word, lnkctl_word, lnkctl2_word, rd_mux;

  assign nonsticky_rst_n = por_n & hot_rst_n;

  assign wr_devctl  = cfg_wr && cfg_addr == ADDR_W'(IDX_DEVCTL);
  assign wr_devctl2 = cfg_wr && cfg_addr == ADDR_W'(IDX_DEVCTL2);
  assign wr_lnkctl  = cfg_wr && cfg_addr == ADDR_W'(IDX_LNKCTL);
  assign wr_lnkctl2 = cfg_wr && cfg_addr == ADDR_W'(IDX_LNKCTL2);

  pcie_cap_dev #(.FLR_CAP(FLR_CAP), .RO_DEF(RO_DEF)) u_dev (
    .clk(clk), .rst_n(nonsticky_rst_n),
    .wr_devctl(wr_devctl), .wr_devctl2(wr_devctl2),
    .wdata(cfg_wdata), .be(cfg_be),
    .err_in(err_event), .txn_pending(txn_pending),
    .devctl_word(devctl_word), .devctl2_word(devctl2_word),
    .flr_pulse(flr_pulse)
  );

  pcie_cap_link #(.TGT_DEF(MAX_SPEED)) u_link (
    .clk(clk), .por_n(por_n), .rst_n(nonsticky_rst_n), .flr_clear(flr_pulse),
    .wr_lnkctl(wr_lnkctl), .wr_lnkctl2(wr_lnkctl2),
    .wdata(cfg_wdata), .be(cfg_be),
    .eq_status(eq_status), .eq_req(eq_req),
    .lnkctl_word(lnkctl_word), .lnkctl2_word(lnkctl2_word)
  );

  always_comb begin
    rd_mux    = '0;
    addr_hole = 1'b0;
    case (cfg_addr)
      ADDR_W'(IDX_HDR):     rd_mux = HDR_WORD;
      ADDR_W'(IDX_DEVCAP):  rd_mux = DEVCAP_WORD;
      ADDR_W'(IDX_DEVCTL):  rd_mux = devctl_word;
      ADDR_W'(IDX_LNKCAP):  rd_mux = LNKCAP_WORD;
      ADDR_W'(IDX_LNKCTL):  rd_mux = lnkctl_word |
                                     {3'b0, SLOT_CLK, 2'b0, link_width, link_speed, 16'b0};
      ADDR_W'(IDX_DEVCAP2): rd_mux = DEVCAP2_WORD;
      ADDR_W'(IDX_DEVCTL2): rd_mux = devctl2_word;
      ADDR_W'(IDX_LNKCAP2): rd_mux = LNKCAP2_WORD;
      ADDR_W'(IDX_LNKCTL2): rd_mux = lnkctl2_word;
      default:              addr_hole = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge nonsticky_rst_n) begin
    if (!nonsticky_rst_n) cfg_rdata <= '0;
    else                  cfg_rdata <= cfg_rd ? rd_mux : '0;
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!nonsticky_rst_n)
    !cfg_rd |=> cfg_rdata == 32'h0);
  assert_hole_zero_R2: assert property (@(posedge clk) disable iff (!nonsticky_rst_n)
    (cfg_rd && addr_hole) |=> cfg_rdata == 32'h0);
  assert_status_ro_R7: assert property (@(posedge clk) disable iff (!nonsticky_rst_n)
    (cfg_rd && cfg_addr == ADDR_W'(IDX_DEVCTL)) |=> cfg_rdata[21] == $past(txn_pending));

endmodule

// File: tb/pcie_cap_regs_tb.sv
module pcie_cap_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, hot_rst_n = 1'b1;
  logic cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_rdata, rdata_nf;
  logic [3:0] err_event = '0;
  logic txn_pending = 1'b0;
  logic [3:0] link_speed = 4'd1;
  logic [5:0] link_width = 6'd4;
  logic [3:0] eq_status = '0;
  logic eq_req = 1'b0;
  logic flr_pulse, flr_nf;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model of writable state
  logic [31:0] m_dc, m_dc2, m_lc, m_lc2;
  logic [3:0]  m_st;
  logic        m_eqr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_cap_regs u_dut (
    .clk(clk), .por_n(por_n), .hot_rst_n(hot_rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .err_event(err_event), .txn_pending(txn_pending), .link_speed(link_speed),
    .link_width(link_width), .eq_status(eq_status), .eq_req(eq_req), .flr_pulse(flr_pulse));

  pcie_cap_regs #(.FLR_CAP(1'b0)) u_dut_noflr (
    .clk(clk), .por_n(por_n), .hot_rst_n(hot_rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(rdata_nf),
    .err_event(err_event), .txn_pending(txn_pending), .link_speed(link_speed),
    .link_width(link_width), .eq_status(eq_status), .eq_req(eq_req), .flr_pulse(flr_nf));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] d,
                                        input logic [3:0] be, input logic [31:0] wm);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 32; b++) if (be[b/8] && wm[b]) r[b] = d[b];
    return r;
  endfunction

  task automatic model_por();
    m_dc = 32'h2810; m_dc2 = 32'h1F; m_lc = 0; m_lc2 = 32'h3; m_st = 0; m_eqr = 0;
  endtask

  task automatic model_soft();
    m_dc = 32'h2810; m_dc2 = 32'h1F; m_lc = 0; m_lc2 = m_lc2 & 32'hFF9F; m_st = 0; m_eqr = 0;
  endtask

  function automatic logic [31:0] expect_word(input int a);
    case (a)
      0:  return (32'h2 << 16) | 32'h10;
      1:  return 32'd1 | (32'd1 << 5) | (32'd7 << 6) | (32'd7 << 9) | (32'd1 << 15) | (32'd1 << 28);
      2:  return m_dc | (32'(m_st) << 16) | (32'(txn_pending) << 21);
      3:  return 32'd3 | (32'd8 << 4) | (32'd3 << 10) | (32'd6 << 12) | (32'd1 << 22);
      4:  return m_lc | (32'(link_speed) << 16) | (32'(link_width) << 20) | (32'd1 << 28);
      9:  return 32'h1F;
      10: return m_dc2;
      11: return 32'hE;
      12: return m_lc2 | (32'(eq_status) << 17) | (32'(m_eqr) << 21);
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    cfg_wr = 1; cfg_addr = a[5:0]; cfg_wdata = d; cfg_be = be;
    case (a)
      2:  begin m_dc = merge(m_dc, d, be, 32'h79FF); if (be[2]) m_st = m_st & ~d[19:16]; end
      4:  m_lc = merge(m_lc, d, be, 32'hCB);
      10: m_dc2 = merge(m_dc2, d, be, 32'h5F);
      12: begin m_lc2 = merge(m_lc2, d, be, 32'hFFBF); if (be[2] && d[21]) m_eqr = 0; end
      default: ;
    endcase
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic rd_chk(input int a, input string tag);
    logic [31:0] e;
    e = expect_word(a);
    cfg_rd = 1; cfg_addr = a[5:0];
    @(negedge clk);
    cfg_rd = 0;
    chk(tag, cfg_rdata, e);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    model_por();
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);

    // R1 R2 R3 R9 R10: full address sweep of reset values
    for (int a = 0; a < 64; a++) rd_chk(a, "R1_R2 reset sweep");
    chk("R2 idle read is zero", cfg_rdata, 32'h0);
    cfg_rd = 1; cfg_addr = 6'd1; @(negedge clk); cfg_rd = 0;
    chk("R1 no-capability devcap bit28", {31'b0, rdata_nf[28]}, 32'h0);

    // R3: byte-enable sweep on device control (bit 15 kept clear)
    for (int be = 0; be < 16; be++) begin
      wr(2, (be % 2 == 0) ? 32'hFFF0_7FFF : 32'h0000_0600, 4'(be));
      rd_chk(2, "R3 devctl byte-enable sweep");
    end
    chk("R4 no pulse without trigger", {31'b0, flr_pulse}, 32'h0);

    // R9
    wr(10, 32'hFFFF_FFFF, 4'hF); rd_chk(10, "R9 devctl2 all ones");
    wr(10, 32'h0, 4'hF);          rd_chk(10, "R9 devctl2 zero");
    wr(10, 32'hFFFF_FFFF, 4'hE); rd_chk(10, "R9 devctl2 lane 0 disabled");

    // R8
    wr(4, 32'hFFFF_FFFF, 4'hF);
    for (int s = 0; s < 4; s++) begin
      link_speed = 4'(s + 1); link_width = 6'(1 << s);
      rd_chk(4, "R8 link control and status");
    end
    wr(4, 32'h0000_0041, 4'h1); rd_chk(4, "R8 link control partial");

    // R11: equalization status sweep
    wr(12, 32'hFFFF_FFFF, 4'hF);
    for (int q = 0; q < 16; q++) begin
      eq_status = 4'(q);
      rd_chk(12, "R11 equalization status bits");
    end
    eq_req = 1; @(negedge clk); eq_req = 0; m_eqr = 1;
    rd_chk(12, "R11 eq request set");
    cfg_wr = 1; cfg_addr = 6'd12; cfg_wdata = 32'h0020_0000; cfg_be = 4'h4; eq_req = 1;
    @(negedge clk); cfg_wr = 0; cfg_be = 0; eq_req = 0;
    rd_chk(12, "R11 set wins over clear");
    wr(12, 32'h0020_0000, 4'h4); rd_chk(12, "R11 write one clears");

    // R6: each error flag set then cleared individually
    for (int b = 0; b < 4; b++) begin
      err_event = 4'(1 << b); @(negedge clk); err_event = 0; m_st = m_st | 4'(1 << b);
      rd_chk(2, "R6 error flag set");
    end
    wr(2, 32'h0005_0000 | m_dc, 4'h4); rd_chk(2, "R6 partial clear");
    cfg_wr = 1; cfg_addr = 6'd2; cfg_wdata = 32'h000F_0000; cfg_be = 4'h4; err_event = 4'b0100;
    m_st = 4'b0100;
    @(negedge clk); cfg_wr = 0; cfg_be = 0; err_event = 0;
    rd_chk(2, "R6 set wins over clear");
    wr(2, 32'h000F_0000, 4'hB); rd_chk(2, "R6 clear needs byte 2 enable");

    // R7
    txn_pending = 1; rd_chk(2, "R7 pending high");
    wr(2, 32'h0000_0000, 4'h4); rd_chk(2, "R7 pending ignores write");
    txn_pending = 0; rd_chk(2, "R7 pending low");

    // R10: hot reset keeps sticky fields
    wr(12, 32'hFFFF_FFFF, 4'h3); wr(4, 32'hFF, 4'h1); wr(2, 32'h0000_01FF, 4'h3);
    hot_rst_n = 0; @(negedge clk); hot_rst_n = 1; model_soft(); @(negedge clk);
    for (int a = 0; a < 13; a++) rd_chk(a, "R10 state after hot reset");

    // R4: trigger with byte 1 disabled has no effect
    wr(2, 32'hFFFF_8000, 4'h1);
    chk("R4 trigger masked by byte enable", {31'b0, flr_pulse}, 32'h0);
    // R4 R5: real function reset
    wr(12, 32'h0000_A5BF, 4'h3); wr(4, 32'hCB, 4'h1); wr(10, 32'h0, 4'h1);
    eq_req = 1; @(negedge clk); eq_req = 0; m_eqr = 1;
    wr(2, 32'h0000_8000, 4'h2);
    chk("R4 pulse asserted", {31'b0, flr_pulse}, 32'h1);
    chk("R4 pulse gated by capability", {31'b0, flr_nf}, 32'h0);
    @(negedge clk);
    chk("R4 pulse lasts one cycle", {31'b0, flr_pulse}, 32'h0);
    model_soft();
    for (int a = 0; a < 13; a++) rd_chk(a, "R5_R10 state after function reset");
    rd_chk(2, "R4 trigger reads zero");

    // R10: power-on reset clears sticky group
    por_n = 0; @(negedge clk); por_n = 1; model_por(); @(negedge clk);
    rd_chk(12, "R10 power-on restores target speed");
    rd_chk(2, "R3 power-on devctl default");

    summary();
  end
endmodule